// File: doc/BRIEF.md
# Event-Driven Waveform Generator Channel

This block is one timer channel running as a waveform source. A 16-bit counter advances on a count-enable strobe. Four kinds of event drive two waveform pins, A and B: a software trigger, an edge on a selectable external line, and equality matches of the counter against three compare registers. Register A steers pin A, register B steers pin B, and register C steers both. Each event carries its own action code for each pin. When several events land in the same cycle, a fixed ranking decides which action applies.

Used with the compare-C trigger, register C sets the period and registers A and B set the two duty cycles of a pair of PWM outputs. The stop and disable options on a C match make a one-shot pulse. Input line B can be chosen as the external event source. In that case pin B stops driving, and only pin A produces a waveform. Sticky flags record compare matches, counter wrap and external events until a status read clears them. Two mirror outputs show the current level of each pin.

Top module: `wavegen_channel`

## Requirements
- R1: After reset both pins are low, the counter is 0, every sticky flag is 0, the counter clock is disabled and stopped, and the mode word is 0. In that mode input B is the event source, so `out_b_oe_n` is 1 while `out_a_oe_n` is 0.
- R2: Each action is a 2-bit code: 0 none, 1 set, 2 clear, 3 toggle. A pin changes on the clock edge at which its winning event is detected. With no live event the pin holds its level.
- R3: The counter advances by one on a clock edge with `cnt_en` high only while the clock is both enabled and started. `clk_on` enables the clock and `clk_off` disables it, with `clk_off` winning if both are high. A disabled clock is also stopped.
- R4: A compare match happens on an advancing edge whose current count equals register A, B or C. Match A acts on pin A, match B acts on pin B, and match C acts on both pins.
- R5: Among the events of one cycle whose action for a pin is not none, the winner ranks as: software trigger, then external event, then C match, then that pin's own compare match.
- R6: `ext_sel` picks the event line: 0 input B, 1 `aux_evt[0]`, 2 `aux_evt[1]`, 3 `aux_evt[2]`. `ext_edge` qualifies it: 0 none, 1 rising, 2 falling, 3 both. An edge is the line's current level compared with its level one clock earlier.
- R7: With `ext_trig_en` set, an external event also clears the counter and starts the clock.
- R8: With `c_trig_en` set, a C match clears the counter in place of incrementing it, so the period is RC+1 advancing edges.
- R9: On a C match, `c_stop` stops the clock, and this wins over any trigger in that cycle. `c_dis` disables the clock; it then needs `clk_on` and a trigger before it counts again.
- R10: While `ext_sel` is 0, pin B holds its level, `out_b_oe_n` is 1, and `mirror_b` shows input B. Otherwise `out_b_oe_n` is 0 and `mirror_b` shows pin B.
- R11: The flags for compare A, B and C, overflow and external event are sticky. `stat_rd` clears them, and a new event in the same cycle keeps its flag set.
- R12: An advancing edge at count 0xFFFF wraps the counter to 0 and sets the overflow flag.
- R13: A software trigger clears the counter on its edge and starts the clock if the clock is enabled.
- R14: `wr_addr` 0 writes the mode word, 1 register A, 2 register B, 3 register C. Mode bits, LSB first: [1:0] A on compare A, [3:2] A on C, [5:4] A on external event, [7:6] A on software trigger; [15:8] the same four fields for pin B, with compare B in place of compare A; [17:16] `ext_sel`; [19:18] `ext_edge`; [20] `ext_trig_en`; [21] `c_trig_en`; [22] `c_stop`; [23] `c_dis`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous reset, active low |
| cnt_en | input | 1 | Count-enable strobe, one pulse per counting step |
| sw_trig | input | 1 | Software trigger pulse |
| clk_on | input | 1 | Enable the counter clock |
| clk_off | input | 1 | Disable the counter clock |
| in_b | input | 1 | Level of line B when it is used as an input |
| aux_evt | input | 3 | Auxiliary external event lines |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register select for writes |
| wr_data | input | 24 | Write data |
| stat_rd | input | 1 | Status read, clears sticky flags |
| out_a | output | 1 | Waveform pin A |
| out_b | output | 1 | Waveform pin B |
| out_a_oe_n | output | 1 | Active-low output enable of pin A |
| out_b_oe_n | output | 1 | Active-low output enable of pin B |
| count | output | 16 | Current counter value |
| st_cmp_a | output | 1 | Sticky compare A flag |
| st_cmp_b | output | 1 | Sticky compare B flag |
| st_cmp_c | output | 1 | Sticky compare C flag |
| st_ovf | output | 1 | Sticky overflow flag |
| st_ext | output | 1 | Sticky external event flag |
| mirror_a | output | 1 | Current level of pin A |
| mirror_b | output | 1 | Current level of line B |

## Verification
The bench sets up same-cycle collisions: a software trigger against a compare A match, and an external edge against a C match. A design with the ranking wrong, or one that lets a "none" action block a lower-ranked event, leaves the pins at the wrong level. It also drives an edge of the wrong polarity, which a careless edge detector would accept, and a C match with stop enabled, where a counter that ignores the stop keeps running. The remaining cases are input-B mode, where a leaky design would still move pin B or keep driving it; a clear-wins enable/disable collision; and a full 16-bit wrap that must raise the overflow flag only on the last step.

// File: rtl/wg_pkg.sv
package wg_pkg;

    // Per-event action applied to a waveform pin.
    typedef enum logic [1:0] {
        ACT_NONE = 2'd0,
        ACT_SET  = 2'd1,
        ACT_CLR  = 2'd2,
        ACT_TGL  = 2'd3
    } act_e;

    // Event kinds per pin, lowest rank at index 0.
    localparam int N_EVT = 4;
    // External event lines: input B plus three auxiliaries.
    localparam int N_SRC = 4;

    // Channel mode word, LSB first: A actions, B actions, source, edge, controls.
    typedef struct packed {
        logic       c_dis;
        logic       c_stop;
        logic       c_trig_en;
        logic       ext_trig_en;
        logic [1:0] ext_edge;
        logic [1:0] ext_sel;
        act_e       b_sw;
        act_e       b_ext;
        act_e       b_c;
        act_e       b_cmp;
        act_e       a_sw;
        act_e       a_ext;
        act_e       a_c;
        act_e       a_cmp;
    } mode_t;

    localparam int MODE_W = $bits(mode_t);

    // New pin level after applying an action to the current level.
    function automatic logic apply_act(input act_e a, input logic cur);
        case (a)
            ACT_SET: return 1'b1;
            ACT_CLR: return 1'b0;
            ACT_TGL: return ~cur;
            default: return cur;
        endcase
    endfunction

endpackage

// File: rtl/wg_evt_detect.sv
// External event detector.
// Keeps a one-cycle history of every event line, picks one line, and
// flags the edge kinds requested by the edge mode (bit0 rising, bit1 falling).
// Assumes the lines are already synchronous to clk.
module wg_evt_detect import wg_pkg::*; (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [N_SRC-1:0] src,
    input  logic [1:0]       sel,
    input  logic [1:0]       edge_mode,
    output logic             evt
);

    logic [N_SRC-1:0] prev;
    logic             cur;
    logic             old;

    // Previous level of every line, so a change of selection sees fresh history.
    always_ff @(posedge clk) begin
        if (!rst_n) prev <= '0;
        else        prev <= src;
    end

    assign cur = src[sel];
    assign old = prev[sel];
    assign evt = (edge_mode[0] & cur & ~old) | (edge_mode[1] & ~cur & old);

    p_edge_is_change_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (evt && $past(rst_n)) |-> (src[sel] != $past(src[sel])));

endmodule

// File: rtl/wg_counter.sv
// Channel counter with enable/start control.
// Counts on tick while enabled and started; a trigger clears the count and
// starts the clock if it is enabled; stop and disable events come from a C match.
// Assumes the stop and disable inputs are already qualified by the mode word.
module wg_counter #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         tick,
    input  logic         trig,
    input  logic         clk_on,
    input  logic         clk_off,
    input  logic         stop_evt,
    input  logic         dis_evt,
    output logic [W-1:0] cnt,
    output logic         adv,
    output logic         wrap
);

    localparam logic [W-1:0] CNT_MAX = '1;

    logic enabled;
    logic started;
    logic en_nx;
    logic st_nx;

    assign adv  = tick & enabled & started;
    assign wrap = adv & (cnt == CNT_MAX) & ~trig;

    // Next enable state: disable wins over enable.
    always_comb begin
        if (clk_off || dis_evt) en_nx = 1'b0;
        else if (clk_on)        en_nx = 1'b1;
        else                    en_nx = enabled;
    end

    // Next start state: a stop on C outranks every trigger.
    always_comb begin
        if (!en_nx)        st_nx = 1'b0;
        else if (stop_evt) st_nx = 1'b0;
        else if (trig)     st_nx = 1'b1;
        else               st_nx = started;
    end

    // Clock control state.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            enabled <= 1'b0;
            started <= 1'b0;
        end else begin
            enabled <= en_nx;
            started <= st_nx;
        end
    end

    // Count register: trigger clears, advancing edge increments.
    always_ff @(posedge clk) begin
        if (!rst_n)    cnt <= '0;
        else if (trig) cnt <= '0;
        else if (adv)  cnt <= cnt + 1'b1;
    end

    p_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!adv && !trig) |=> $stable(cnt));
    p_trig_clears_r13: assert property (@(posedge clk) disable iff (!rst_n)
        trig |=> (cnt == '0));
    p_wrap_zero_r12: assert property (@(posedge clk) disable iff (!rst_n)
        wrap |=> (cnt == '0));
    p_stop_halts_r9: assert property (@(posedge clk) disable iff (!rst_n)
        stop_evt |=> !started);
    p_run_needs_en_r3: assert property (@(posedge clk) disable iff (!rst_n)
        started |-> enabled);

endmodule

// File: rtl/wg_out_ctl.sv
// Output controller for one waveform pin.
// Takes N_EVT event strobes (index 0 lowest rank) with a 2-bit action each;
// the highest-ranked strobe whose action is not none is applied on this edge.
// hold freezes the pin when the line is used as an input.
module wg_out_ctl import wg_pkg::*; (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               hold,
    input  logic [N_EVT-1:0]   ev,
    input  logic [2*N_EVT-1:0] act_codes,
    output logic               q
);

    logic [N_EVT-1:0] live;
    act_e             win;

    for (genvar i = 0; i < N_EVT; i++) begin : g_live
        assign live[i] = ev[i] & (act_codes[2*i +: 2] != 2'd0);
    end

    // Rank resolution: later (higher-index) live events override earlier ones.
    always_comb begin
        win = ACT_NONE;
        for (int i = 0; i < N_EVT; i++) begin
            if (live[i]) win = act_e'(act_codes[2*i +: 2]);
        end
    end

    // Pin register.
    always_ff @(posedge clk) begin
        if (!rst_n)                        q <= 1'b0;
        else if (!hold && win != ACT_NONE) q <= apply_act(win, q);
    end

    p_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!(|live) || hold) |=> $stable(q));
    p_top_rank_set_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (ev[N_EVT-1] && act_codes[2*N_EVT-1 -: 2] == 2'd1 && !hold) |=> q);

endmodule

// File: rtl/wavegen_channel.sv
// Waveform generator channel top.
// Holds the mode word and compare registers, builds compare, external and
// trigger events, feeds them to two pin controllers and keeps sticky flags.
// Assumes all inputs are synchronous to clk; clock-source selection is external
// and arrives as the cnt_en strobe.
module wavegen_channel import wg_pkg::*; #(
    parameter int CNT_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cnt_en,
    input  logic              sw_trig,
    input  logic              clk_on,
    input  logic              clk_off,
    input  logic              in_b,
    input  logic [2:0]        aux_evt,
    input  logic              wr_en,
    input  logic [1:0]        wr_addr,
    input  logic [MODE_W-1:0] wr_data,
    input  logic              stat_rd,
    output logic              out_a,
    output logic              out_b,
    output logic              out_a_oe_n,
    output logic              out_b_oe_n,
    output logic [CNT_W-1:0]  count,
    output logic              st_cmp_a,
    output logic              st_cmp_b,
    output logic              st_cmp_c,
    output logic              st_ovf,
    output logic              st_ext,
    output logic              mirror_a,
    output logic              mirror_b
);

    localparam int             N_PIN   = 2;
    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    mode_t            mode_q;
    logic [CNT_W-1:0] reg_a;
    logic [CNT_W-1:0] reg_b;
    logic [CNT_W-1:0] reg_c;

    logic ext_evt;
    logic adv;
    logic wrap;
    logic cmp_a;
    logic cmp_b;
    logic cmp_c;
    logic trig;
    logic b_is_in;

    logic [N_PIN-1:0][N_EVT-1:0]   ev_v;
    logic [N_PIN-1:0][2*N_EVT-1:0] act_v;
    logic [N_PIN-1:0]              hold_v;
    logic [N_PIN-1:0]              q_v;

    // Configuration registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_q <= '0;
            reg_a  <= '0;
            reg_b  <= '0;
            reg_c  <= '0;
        end else if (wr_en) begin
            case (wr_addr)
                2'd0:    mode_q <= mode_t'(wr_data);
                2'd1:    reg_a  <= wr_data[CNT_W-1:0];
                2'd2:    reg_b  <= wr_data[CNT_W-1:0];
                default: reg_c  <= wr_data[CNT_W-1:0];
            endcase
        end
    end

    wg_evt_detect u_evt (
        .clk       (clk),
        .rst_n     (rst_n),
        .src       ({aux_evt, in_b}),
        .sel       (mode_q.ext_sel),
        .edge_mode (mode_q.ext_edge),
        .evt       (ext_evt)
    );

    assign cmp_a   = adv & (count == reg_a);
    assign cmp_b   = adv & (count == reg_b);
    assign cmp_c   = adv & (count == reg_c);
    assign trig    = sw_trig | (ext_evt & mode_q.ext_trig_en) | (cmp_c & mode_q.c_trig_en);
    assign b_is_in = (mode_q.ext_sel == 2'd0);

    wg_counter #(.W(CNT_W)) u_cnt (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick     (cnt_en),
        .trig     (trig),
        .clk_on   (clk_on),
        .clk_off  (clk_off),
        .stop_evt (cmp_c & mode_q.c_stop),
        .dis_evt  (cmp_c & mode_q.c_dis),
        .cnt      (count),
        .adv      (adv),
        .wrap     (wrap)
    );

    // Event and action vectors per pin, highest rank in the top slot.
    assign ev_v[0]  = {sw_trig, ext_evt, cmp_c, cmp_a};
    assign ev_v[1]  = {sw_trig, ext_evt, cmp_c, cmp_b};
    assign act_v[0] = {mode_q.a_sw, mode_q.a_ext, mode_q.a_c, mode_q.a_cmp};
    assign act_v[1] = {mode_q.b_sw, mode_q.b_ext, mode_q.b_c, mode_q.b_cmp};
    assign hold_v   = {b_is_in, 1'b0};

    for (genvar k = 0; k < N_PIN; k++) begin : g_pin
        wg_out_ctl u_oc (
            .clk       (clk),
            .rst_n     (rst_n),
            .hold      (hold_v[k]),
            .ev        (ev_v[k]),
            .act_codes (act_v[k]),
            .q         (q_v[k])
        );
    end

    // Sticky flags: a new event outranks the clearing read.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_cmp_a <= 1'b0;
            st_cmp_b <= 1'b0;
            st_cmp_c <= 1'b0;
            st_ovf   <= 1'b0;
            st_ext   <= 1'b0;
        end else begin
            st_cmp_a <= (st_cmp_a & ~stat_rd) | cmp_a;
            st_cmp_b <= (st_cmp_b & ~stat_rd) | cmp_b;
            st_cmp_c <= (st_cmp_c & ~stat_rd) | cmp_c;
            st_ovf   <= (st_ovf   & ~stat_rd) | wrap;
            st_ext   <= (st_ext   & ~stat_rd) | ext_evt;
        end
    end

    assign out_a      = q_v[0];
    assign out_b      = q_v[1];
    assign out_a_oe_n = 1'b0;
    assign out_b_oe_n = b_is_in;
    assign mirror_a   = q_v[0];
    assign mirror_b   = b_is_in ? in_b : q_v[1];

    p_bhold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (b_is_in && $past(b_is_in)) |-> $stable(out_b));
    p_flagc_needs_tick_r11: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(st_cmp_c) |-> $past(cnt_en));
    p_ovf_from_max_r12: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(st_ovf) |-> ($past(count) == CNT_MAX));
    p_swtrig_zero_r13: assert property (@(posedge clk) disable iff (!rst_n)
        sw_trig |=> (count == '0));

endmodule

// File: tb/wavegen_channel_test.sv
module wavegen_channel_test;

    localparam int W  = 16;
    localparam int NV = 17;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cnt_en = 1'b0, sw_trig = 1'b0, clk_on = 1'b0, clk_off = 1'b0;
    logic        in_b = 1'b0;
    logic [2:0]  aux_evt = 3'b000;
    logic        wr_en = 1'b0;
    logic [1:0]  wr_addr = 2'd0;
    logic [23:0] wr_data = '0;
    logic        stat_rd = 1'b0;
    logic        out_a, out_b, out_a_oe_n, out_b_oe_n;
    logic [W-1:0] count;
    logic        st_cmp_a, st_cmp_b, st_cmp_c, st_ovf, st_ext, mirror_a, mirror_b;

    int n_run = 0;
    int n_fail = 0;

    always #10 clk = ~clk;

    wavegen_channel #(.CNT_W(W)) uut (
        .clk(clk), .rst_n(rst_n), .cnt_en(cnt_en), .sw_trig(sw_trig),
        .clk_on(clk_on), .clk_off(clk_off), .in_b(in_b), .aux_evt(aux_evt),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data), .stat_rd(stat_rd),
        .out_a(out_a), .out_b(out_b), .out_a_oe_n(out_a_oe_n), .out_b_oe_n(out_b_oe_n),
        .count(count), .st_cmp_a(st_cmp_a), .st_cmp_b(st_cmp_b), .st_cmp_c(st_cmp_c),
        .st_ovf(st_ovf), .st_ext(st_ext), .mirror_a(mirror_a), .mirror_b(mirror_b)
    );

    // Vector: {cnt_en, sw_trig, aux0, exp out_a, exp out_b, exp count}
    localparam logic [20:0] VEC [NV] = '{
        {3'b010, 2'b10, 16'd0},
        {3'b100, 2'b10, 16'd1},
        {3'b100, 2'b11, 16'd2},
        {3'b100, 2'b01, 16'd3},
        {3'b100, 2'b10, 16'd0},
        {3'b000, 2'b10, 16'd0},
        {3'b101, 2'b00, 16'd1},
        {3'b101, 2'b01, 16'd2},
        {3'b111, 2'b10, 16'd0},
        {3'b100, 2'b10, 16'd1},
        {3'b101, 2'b01, 16'd2},
        {3'b101, 2'b01, 16'd3},
        {3'b100, 2'b10, 16'd0},
        {3'b100, 2'b10, 16'd1},
        {3'b100, 2'b11, 16'd2},
        {3'b100, 2'b01, 16'd3},
        {3'b101, 2'b10, 16'd0}
    };

    task automatic chk(input string tag, input string what, input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic wr(input logic [1:0] a, input logic [23:0] d);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        step();
        wr_en = 1'b0;
    endtask

    task automatic ticks(input int n);
        cnt_en = 1'b1;
        for (int i = 0; i < n; i++) step();
        cnt_en = 1'b0;
    endtask

    task automatic pulse_sw();
        sw_trig = 1'b1; step(); sw_trig = 1'b0;
    endtask

    function automatic logic [23:0] mk_mode(
        input logic dis, input logic stp, input logic ctrg, input logic etrg,
        input logic [1:0] edg, input logic [1:0] sel,
        input logic [1:0] b_sw, input logic [1:0] b_ext, input logic [1:0] b_c, input logic [1:0] b_cmp,
        input logic [1:0] a_sw, input logic [1:0] a_ext, input logic [1:0] a_c, input logic [1:0] a_cmp);
        return {dis, stp, ctrg, etrg, edg, sel, b_sw, b_ext, b_c, b_cmp, a_sw, a_ext, a_c, a_cmp};
    endfunction

    // Watchdog: an expired run counts as a failed check.
    initial begin
        repeat (150000) @(posedge clk);
        n_run++; n_fail++;
        $display("FAIL watchdog R3: actual hung expected done");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        step();
        // R1 reset state
        chk("R1", "out_a", out_a, 0);
        chk("R1", "out_b", out_b, 0);
        chk("R1", "oe_n_a", out_a_oe_n, 0);
        chk("R1", "oe_n_b", out_b_oe_n, 1);
        chk("R1", "count", count, 0);
        chk("R1", "flags", {st_cmp_a, st_cmp_b, st_cmp_c, st_ovf, st_ext}, 0);
        chk("R1", "mirror", {mirror_a, mirror_b}, 0);

        // PWM set-up: R14 layout, RA=2 RB=1 RC=3, C trigger on
        clk_on = 1'b1; step(); clk_on = 1'b0;
        wr(2'd0, mk_mode(0, 0, 1, 0, 2'd1, 2'd1, 2'd2, 2'd0, 2'd2, 2'd3, 2'd1, 2'd3, 2'd1, 2'd2));
        wr(2'd1, 24'd2);
        wr(2'd2, 24'd1);
        wr(2'd3, 24'd3);

        // Table walk: R2 R4 R5 R6 R8
        for (int i = 0; i < NV; i++) begin
            {cnt_en, sw_trig, aux_evt[0]} = VEC[i][20:18];
            step();
            chk("R2 R4 R5 R6 R8", $sformatf("vec %0d out_a", i), out_a, VEC[i][17]);
            chk("R2 R4 R5 R8", $sformatf("vec %0d out_b", i), out_b, VEC[i][16]);
            chk("R8 R13", $sformatf("vec %0d count", i), count, VEC[i][15:0]);
        end
        cnt_en = 1'b0; sw_trig = 1'b0; aux_evt[0] = 1'b0;
        step();

        // R11 sticky flags, then clear by read
        chk("R11", "flags set", {st_cmp_a, st_cmp_b, st_cmp_c, st_ovf, st_ext}, 5'b11101);
        stat_rd = 1'b1; step(); stat_rd = 1'b0;
        chk("R11", "flags cleared", {st_cmp_a, st_cmp_b, st_cmp_c, st_ovf, st_ext}, 0);

        // R7 external falling edge on aux1 resets counter
        wr(2'd0, mk_mode(0, 0, 0, 1, 2'd2, 2'd2, 0, 0, 0, 0, 0, 0, 0, 0));
        pulse_sw();
        ticks(3);
        chk("R7", "count before", count, 3);
        aux_evt[1] = 1'b1; cnt_en = 1'b1; step(); cnt_en = 1'b0;
        chk("R6", "rising ignored", count, 4);
        aux_evt[1] = 1'b0; step();
        chk("R7", "count after fall", count, 0);
        chk("R11", "ext flag", st_ext, 1);

        // R10 input B as event source
        wr(2'd0, mk_mode(0, 0, 0, 0, 2'd1, 2'd0, 2'd1, 2'd1, 0, 0, 0, 2'd3, 0, 0));
        chk("R10", "oe_n_b input", out_b_oe_n, 1);
        chk("R10", "oe_n_a", out_a_oe_n, 0);
        in_b = 1'b1; step();
        chk("R10", "out_a toggled by in_b", out_a, 0);
        chk("R10", "out_b held", out_b, 0);
        chk("R10", "mirror_b", mirror_b, 1);
        pulse_sw();
        chk("R10", "out_b ignores sw", out_b, 0);
        in_b = 1'b0; step();
        chk("R10", "mirror_b low", mirror_b, 0);
        wr(2'd0, mk_mode(0, 0, 0, 0, 2'd0, 2'd1, 2'd1, 0, 0, 0, 0, 0, 0, 0));
        chk("R10", "oe_n_b output", out_b_oe_n, 0);
        pulse_sw();
        chk("R10", "out_b driven", out_b, 1);

        // R9 stop on C with C trigger
        wr(2'd0, mk_mode(0, 1, 1, 0, 0, 2'd1, 0, 0, 0, 0, 0, 0, 0, 0));
        pulse_sw();
        ticks(3);
        chk("R9", "count at C", count, 3);
        ticks(1);
        chk("R9", "reset at C", count, 0);
        ticks(3);
        chk("R9", "stopped", count, 0);
        pulse_sw();
        ticks(1);
        chk("R9", "restart", count, 1);

        // R9 disable on C
        wr(2'd0, mk_mode(1, 0, 0, 0, 0, 2'd1, 0, 0, 0, 0, 0, 0, 0, 0));
        pulse_sw();
        ticks(4);
        ticks(3);
        chk("R9", "disabled hold", count, 4);
        pulse_sw();
        ticks(2);
        chk("R9", "trig no start", count, 0);
        clk_on = 1'b1; step(); clk_on = 1'b0;
        pulse_sw();
        ticks(1);
        chk("R9", "re-enabled", count, 1);

        // R3 disable wins over enable
        clk_on = 1'b1; clk_off = 1'b1; step(); clk_on = 1'b0; clk_off = 1'b0;
        ticks(2);
        chk("R3", "off wins", count, 1);

        // R12 full wrap
        clk_on = 1'b1; step(); clk_on = 1'b0;
        wr(2'd0, 24'd0);
        pulse_sw();
        ticks(65535);
        chk("R12", "count max", count, 16'hFFFF);
        chk("R12", "no ovf yet", st_ovf, 0);
        ticks(1);
        chk("R12", "wrapped", count, 0);
        chk("R12", "ovf flag", st_ovf, 1);

        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule